// File: doc/BRIEF.md
# Second-Operand Shifter with Rotated-Constant Expander

This combinational block forms the second operand of a 32-bit data-processing datapath. In register mode it takes a register value and moves it by one of five shift kinds. The distance comes either from a small immediate field or from the low byte of a second register. The block returns the moved value together with a shifter carry-out. In constant mode it ignores the register path. It widens an 8-bit constant to the datapath width and rotates it right by twice a 4-bit rotation field.

The carry-out is produced on every evaluation, whether or not the following flag logic uses it. Logical operations downstream can then take their carry from the shifter. The source register is never written. Only the produced operand reflects the shift. Instruction decoding and the ALU sit outside this block.

Top module: `op_shifter`

## Requirements
- R1: Kind code 0 is a left logical shift. For distances 1..31 the result is the value shifted left and the carry is the last bit shifted out. A distance of 32 gives result 0 with carry equal to value bit 0. Any distance above 32 gives result 0 with carry 0.
- R2: Kind code 1 is a right logical shift. For distances 1..31 the result is zero-filled and the carry is the last bit shifted out. A distance of 32 gives result 0 with carry equal to value bit 31. Any distance above 32 gives result 0 with carry 0.
- R3: Kind code 2 is an arithmetic right shift that fills with value bit 31. For distances 1..31 the carry is the last bit shifted out. Any distance of 32 or more gives every result bit and the carry equal to value bit 31.
- R4: Kind code 3 rotates right by the distance modulo 32 for any nonzero distance. The carry equals bit 31 of the result, so a nonzero multiple of 32 returns the value with carry equal to its bit 31.
- R5: Kind code 4 is a one-bit rotate through carry, whatever the distance. The result is {carry_i, value[31:1]} and the carry-out is value bit 0.
- R6: For kind codes 0..3, a distance of 0 returns the value unchanged with carry_o equal to carry_i.
- R7: When amt_src_i is 0 the distance is amt_imm_i. When it is 1 the distance is amt_reg_i[7:0], and bits 31:8 of amt_reg_i have no effect.
- R8: When imm_mode_i is 1 the result is imm_val_i, zero-extended to 32 bits and rotated right by 2*imm_rot_i. opnd_i, kind_i and the distance inputs have no effect.
- R9: In constant mode, carry_o equals carry_i when imm_rot_i is 0. Otherwise it equals bit 31 of the result.
- R10: Kind codes 5, 6 and 7 are reserved. They return the value unchanged with carry_o equal to carry_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Register value to be shifted |
| kind_i | input | 3 | Shift kind: 0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 rotate through carry, 5..7 reserved |
| amt_src_i | input | 1 | Distance source: 0 immediate field, 1 register low byte |
| amt_imm_i | input | 6 | Immediate shift distance |
| amt_reg_i | input | 32 | Register holding the distance in bits 7:0 |
| carry_i | input | 1 | Current carry flag |
| imm_mode_i | input | 1 | 1 selects the rotated 8-bit constant |
| imm_val_i | input | 8 | 8-bit constant |
| imm_rot_i | input | 4 | Rotation field; the rotation is twice this value |
| opnd_o | output | 32 | Produced operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The embedded assertions check several rules on every evaluation. These are the out-of-range zero results of the logical shifts and the sign saturation of the arithmetic shift. They also cover the carry placement of the rotate through carry, the pass-through at distance zero, the population count the constant rotation must preserve, and the carry choice in constant mode. The bench's behavioural model compares every result bit and the carry on every cycle. Only that comparison can show the exact in-range shifted values and the last-bit-out carries. It also shows that the distance really comes from the selected source with the upper register bits ignored, and that the constant lands at the right rotation, for example 0x400 from constant 1 with field 11.

// File: rtl/opsh_pkg.sv
package opsh_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned AMT_W     = 8;
  localparam int unsigned IMM_AMT_W = 6;
  localparam int unsigned CONST_W   = 8;
  localparam int unsigned CROT_W    = 4;

  typedef enum logic [2:0] {
    SK_LSL = 3'd0,
    SK_LSR = 3'd1,
    SK_ASR = 3'd2,
    SK_ROR = 3'd3,
    SK_RRX = 3'd4
  } shift_kind_e;
endpackage

// File: rtl/opsh_fill_shr.sv
// Right shift on {val, guard}; the guard bit ends up holding the last bit shifted out.
module opsh_fill_shr #(
  parameter int unsigned W   = 32,
  parameter int unsigned A_W = $clog2(W + 1)
) (
  input  logic [W-1:0]   val_i,
  input  logic           fill_i,
  input  logic [A_W-1:0] amt_i,
  output logic [W-1:0]   res_o,
  output logic           out_bit_o
);
  for (genvar k = 0; k < A_W; k++) begin : g_st
    localparam int unsigned S = 2 ** k;
    logic [W:0] d;
    logic [W:0] q;
    if (k == 0) begin : g_seed
      assign d = {val_i, 1'b0};
    end else begin : g_chain
      assign d = g_st[k-1].q;
    end
    assign q = amt_i[k] ? {{S{fill_i}}, d[W:S]} : d;
  end

  assign res_o     = g_st[A_W-1].q[W:1];
  assign out_bit_o = g_st[A_W-1].q[0];
endmodule

// File: rtl/opsh_rotr.sv
module opsh_rotr #(
  parameter int unsigned W   = 32,
  parameter int unsigned A_W = $clog2(W)
) (
  input  logic [W-1:0]   val_i,
  input  logic [A_W-1:0] amt_i,
  output logic [W-1:0]   res_o
);
  for (genvar k = 0; k < A_W; k++) begin : g_st
    localparam int unsigned S = 2 ** k;
    logic [W-1:0] d;
    logic [W-1:0] q;
    if (k == 0) begin : g_seed
      assign d = val_i;
    end else begin : g_chain
      assign d = g_st[k-1].q;
    end
    assign q = amt_i[k] ? {d[S-1:0], d[W-1:S]} : d;
  end

  assign res_o = g_st[A_W-1].q;
endmodule

// File: rtl/opsh_const_exp.sv
module opsh_const_exp #(
  parameter int unsigned W      = 32,
  parameter int unsigned C_W    = 8,
  parameter int unsigned CROT_W = 4
) (
  input  logic [C_W-1:0]    cval_i,
  input  logic [CROT_W-1:0] crot_i,
  input  logic              cin_i,
  output logic [W-1:0]      res_o,
  output logic              cout_o
);
  localparam int unsigned R_W = $clog2(W);

  logic [W-1:0]   wide;
  logic [R_W-1:0] rot_amt;

  assign wide    = {{(W - C_W){1'b0}}, cval_i};
  assign rot_amt = R_W'({crot_i, 1'b0});

  opsh_rotr #(.W(W), .A_W(R_W)) i_rot (
    .val_i (wide),
    .amt_i (rot_amt),
    .res_o (res_o)
  );

  assign cout_o = (crot_i == '0) ? cin_i : res_o[W-1];

  always_comb begin
    p_const_bits_kept_r8: assert ($countones(res_o) == $countones(cval_i))
      else $error("constant rotation lost or gained bits");
  end
endmodule

// File: rtl/opsh_reg_shift.sv
module opsh_reg_shift
  import opsh_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned AMT_W = 8
) (
  input  logic [W-1:0]     val_i,
  input  logic [2:0]       kind_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             cin_i,
  output logic [W-1:0]     res_o,
  output logic             cout_o
);
  localparam int unsigned S_W = $clog2(W + 1);
  localparam int unsigned R_W = $clog2(W);

  logic           in_range;
  logic [S_W-1:0] amt_s;
  logic [R_W-1:0] amt_r;
  logic           sign;
  logic [W-1:0]   val_rev, shl_rev, shl_res, shr_res, rot_res;
  logic           shl_bit, shr_bit, shr_fill;

  assign in_range = (amt_i <= AMT_W'(W));
  assign amt_s    = amt_i[S_W-1:0];
  assign amt_r    = amt_i[R_W-1:0];
  assign sign     = val_i[W-1];
  assign shr_fill = (kind_i == SK_ASR) ? sign : 1'b0;

  // Left shift reuses the right shifter on the bit-reversed value.
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign val_rev[i] = val_i[W-1-i];
    assign shl_res[i] = shl_rev[W-1-i];
  end

  opsh_fill_shr #(.W(W), .A_W(S_W)) i_shl (
    .val_i     (val_rev),
    .fill_i    (1'b0),
    .amt_i     (amt_s),
    .res_o     (shl_rev),
    .out_bit_o (shl_bit)
  );

  opsh_fill_shr #(.W(W), .A_W(S_W)) i_shr (
    .val_i     (val_i),
    .fill_i    (shr_fill),
    .amt_i     (amt_s),
    .res_o     (shr_res),
    .out_bit_o (shr_bit)
  );

  opsh_rotr #(.W(W), .A_W(R_W)) i_ror (
    .val_i (val_i),
    .amt_i (amt_r),
    .res_o (rot_res)
  );

  always_comb begin
    res_o  = val_i;
    cout_o = cin_i;
    if (kind_i == SK_RRX) begin
      res_o  = {cin_i, val_i[W-1:1]};
      cout_o = val_i[0];
    end else if (amt_i != '0) begin
      case (kind_i)
        SK_LSL: begin
          res_o  = in_range ? shl_res : '0;
          cout_o = in_range ? shl_bit : 1'b0;
        end
        SK_LSR: begin
          res_o  = in_range ? shr_res : '0;
          cout_o = in_range ? shr_bit : 1'b0;
        end
        SK_ASR: begin
          res_o  = in_range ? shr_res : {W{sign}};
          cout_o = in_range ? shr_bit : sign;
        end
        SK_ROR: begin
          res_o  = rot_res;
          cout_o = rot_res[W-1];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    if ((kind_i == SK_LSL || kind_i == SK_LSR) && amt_i > AMT_W'(W)) begin
      p_logic_over_r1: assert (res_o == '0 && !cout_o)
        else $error("logical shift past width not cleared");
    end
    if (kind_i == SK_ASR && amt_i >= AMT_W'(W)) begin
      p_asr_saturate_r3: assert (($countones(res_o) == 0 || $countones(res_o) == W) && res_o[0] == sign && cout_o == sign)
        else $error("arithmetic shift did not saturate to sign");
    end
    if (kind_i == SK_RRX) begin
      p_rrx_carry_r5: assert (res_o[W-1] == cin_i && cout_o == val_i[0])
        else $error("rotate through carry misplaced carry");
    end
    if (kind_i < SK_RRX && amt_i == '0) begin
      p_zero_pass_r6: assert (res_o == val_i && cout_o == cin_i)
        else $error("zero distance altered operand");
    end
    if (kind_i > SK_RRX) begin
      p_reserved_pass_r10: assert (res_o == val_i && cout_o == cin_i)
        else $error("reserved kind altered operand");
    end
  end
endmodule

// File: rtl/op_shifter.sv
module op_shifter
  import opsh_pkg::*;
#(
  parameter int unsigned W         = DATA_W,
  parameter int unsigned A_W       = AMT_W,
  parameter int unsigned IA_W      = IMM_AMT_W,
  parameter int unsigned C_W       = CONST_W,
  parameter int unsigned CR_W      = CROT_W
) (
  input  logic [W-1:0]    opnd_i,
  input  logic [2:0]      kind_i,
  input  logic            amt_src_i,
  input  logic [IA_W-1:0] amt_imm_i,
  input  logic [W-1:0]    amt_reg_i,
  input  logic            carry_i,
  input  logic            imm_mode_i,
  input  logic [C_W-1:0]  imm_val_i,
  input  logic [CR_W-1:0] imm_rot_i,
  output logic [W-1:0]    opnd_o,
  output logic            carry_o
);
  logic [A_W-1:0] amt_sel;
  logic [W-1:0]   reg_res, cst_res;
  logic           reg_c, cst_c;

  assign amt_sel = amt_src_i ? amt_reg_i[A_W-1:0] : A_W'(amt_imm_i);

  opsh_reg_shift #(.W(W), .AMT_W(A_W)) i_reg_shift (
    .val_i  (opnd_i),
    .kind_i (kind_i),
    .amt_i  (amt_sel),
    .cin_i  (carry_i),
    .res_o  (reg_res),
    .cout_o (reg_c)
  );

  opsh_const_exp #(.W(W), .C_W(C_W), .CROT_W(CR_W)) i_const_exp (
    .cval_i (imm_val_i),
    .crot_i (imm_rot_i),
    .cin_i  (carry_i),
    .res_o  (cst_res),
    .cout_o (cst_c)
  );

  assign opnd_o  = imm_mode_i ? cst_res : reg_res;
  assign carry_o = imm_mode_i ? cst_c   : reg_c;

  always_comb begin
    if (imm_mode_i && imm_rot_i == '0) begin
      p_const_carry_keep_r9: assert (carry_o == carry_i && opnd_o == W'(imm_val_i))
        else $error("unrotated constant changed carry or value");
    end
    if (imm_mode_i && imm_rot_i != '0) begin
      p_const_carry_msb_r9: assert (carry_o == opnd_o[W-1])
        else $error("rotated constant carry not result msb");
    end
  end
endmodule

// File: tb/test_op_shifter.sv
module test_op_shifter;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic [31:0] opnd_i = '0;
  logic [2:0]  kind_i = '0;
  logic        amt_src_i = 1'b0;
  logic [5:0]  amt_imm_i = '0;
  logic [31:0] amt_reg_i = '0;
  logic        carry_i = 1'b0;
  logic        imm_mode_i = 1'b0;
  logic [7:0]  imm_val_i = '0;
  logic [3:0]  imm_rot_i = '0;
  logic [31:0] opnd_o;
  logic        carry_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  op_shifter i_op_shifter (
    .opnd_i     (opnd_i),
    .kind_i     (kind_i),
    .amt_src_i  (amt_src_i),
    .amt_imm_i  (amt_imm_i),
    .amt_reg_i  (amt_reg_i),
    .carry_i    (carry_i),
    .imm_mode_i (imm_mode_i),
    .imm_val_i  (imm_val_i),
    .imm_rot_i  (imm_rot_i),
    .opnd_o     (opnd_o),
    .carry_o    (carry_o)
  );

  // Behavioural model: one bit position per step.
  task automatic model(output logic [31:0] r, output logic c, output string tag);
    int n;
    logic [31:0] v;
    logic cc;
    v = opnd_i;
    cc = carry_i;
    if (imm_mode_i) begin
      v = {24'd0, imm_val_i};
      for (int s = 0; s < 2 * imm_rot_i; s++) v = {v[0], v[31:1]};
      cc = (imm_rot_i == 0) ? carry_i : v[31];
      tag = "R8 R9";
    end else begin
      n = amt_src_i ? int'(amt_reg_i[7:0]) : int'(amt_imm_i);
      case (kind_i)
        3'd0: begin tag = "R1"; for (int s = 0; s < n; s++) begin cc = v[31]; v = v << 1; end end
        3'd1: begin tag = "R2"; for (int s = 0; s < n; s++) begin cc = v[0]; v = v >> 1; end end
        3'd2: begin tag = "R3"; for (int s = 0; s < n; s++) begin cc = v[0]; v = {v[31], v[31:1]}; end end
        3'd3: begin tag = "R4"; for (int s = 0; s < n; s++) begin cc = v[0]; v = {v[0], v[31:1]}; end end
        3'd4: begin tag = "R5"; cc = v[0]; v = {carry_i, v[31:1]}; end
        default: tag = "R10";
      endcase
      if (kind_i < 3'd4 && n == 0) tag = "R6";
      if (amt_src_i) tag = {tag, " R7"};
    end
    r = v;
    c = cc;
  endtask

  task automatic check_now();
    logic [31:0] er;
    logic ec;
    string tag;
    model(er, ec, tag);
    checks++;
    if (opnd_o !== er || carry_o !== ec) begin
      errors++;
      $display("FAIL %s: operand %h carry %b, expected operand %h carry %b", tag, opnd_o, carry_o, er, ec);
    end
  endtask

  task automatic apply(input logic [31:0] v, input logic [2:0] k, input logic src,
                       input logic [5:0] ai, input logic [31:0] ar, input logic ci,
                       input logic im, input logic [7:0] iv, input logic [3:0] ir);
    @(posedge clk);
    opnd_i = v; kind_i = k; amt_src_i = src; amt_imm_i = ai; amt_reg_i = ar;
    carry_i = ci; imm_mode_i = im; imm_val_i = iv; imm_rot_i = ir;
    @(negedge clk);
    check_now();
  endtask

  initial begin
    @(negedge clk);
    // all-zero inputs give a zero operand and carry
    checks++;
    if (opnd_o !== 32'd0 || carry_o !== 1'b0) begin
      errors++;
      $display("FAIL R6: idle operand %h carry %b, expected 00000000 0", opnd_o, carry_o);
    end
    // R1 edges
    apply(32'h8000_0001, 3'd0, 1'b0, 6'd1,  '0, 1'b0, 1'b0, 8'h00, 4'd0);
    apply(32'h0000_0003, 3'd0, 1'b0, 6'd31, '0, 1'b0, 1'b0, 8'h00, 4'd0);
    apply(32'h0000_0001, 3'd0, 1'b0, 6'd32, '0, 1'b0, 1'b0, 8'h00, 4'd0);
    apply(32'hFFFF_FFFF, 3'd0, 1'b1, 6'd0,  32'hABCD_EF21, 1'b1, 1'b0, 8'h00, 4'd0);
    // R2 edges
    apply(32'h8000_0000, 3'd1, 1'b1, 6'd0,  32'h0000_0020, 1'b0, 1'b0, 8'h00, 4'd0);
    apply(32'hFFFF_FFFF, 3'd1, 1'b1, 6'd0,  32'hFF00_0028, 1'b1, 1'b0, 8'h00, 4'd0);
    apply(32'hF000_0010, 3'd1, 1'b0, 6'd5,  '0, 1'b0, 1'b0, 8'h00, 4'd0);
    // R3 edges
    apply(32'h8000_0010, 3'd2, 1'b0, 6'd5,  '0, 1'b0, 1'b0, 8'h00, 4'd0);
    apply(32'h8000_0000, 3'd2, 1'b0, 6'd32, '0, 1'b0, 1'b0, 8'h00, 4'd0);
    apply(32'h8000_0000, 3'd2, 1'b1, 6'd0,  32'h0000_00C8, 1'b0, 1'b0, 8'h00, 4'd0);
    apply(32'h7FFF_FFFF, 3'd2, 1'b1, 6'd0,  32'h0000_00FF, 1'b1, 1'b0, 8'h00, 4'd0);
    // R4 and R6
    apply(32'h1234_5678, 3'd3, 1'b0, 6'd8,  '0, 1'b0, 1'b0, 8'h00, 4'd0);
    apply(32'h8765_4321, 3'd3, 1'b0, 6'd32, '0, 1'b0, 1'b0, 8'h00, 4'd0);
    apply(32'h1234_5679, 3'd3, 1'b1, 6'd0,  32'h0000_0024, 1'b0, 1'b0, 8'h00, 4'd0);
    apply(32'h1234_5678, 3'd3, 1'b0, 6'd0,  '0, 1'b1, 1'b0, 8'h00, 4'd0);
    apply(32'h1234_5678, 3'd0, 1'b1, 6'd9,  32'hFFFF_FF00, 1'b1, 1'b0, 8'h00, 4'd0);
    // R5, R10
    apply(32'h0000_0003, 3'd4, 1'b0, 6'd7,  '0, 1'b1, 1'b0, 8'h00, 4'd0);
    apply(32'hDEAD_BEEF, 3'd6, 1'b0, 6'd4,  '0, 1'b1, 1'b0, 8'h00, 4'd0);
    // R8 and R9: constant 1 with field 11 gives 0x400
    apply(32'hFFFF_FFFF, 3'd1, 1'b0, 6'd3,  '0, 1'b0, 1'b1, 8'h01, 4'd11);
    checks++;
    if (opnd_o !== 32'h0000_0400) begin
      errors++;
      $display("FAIL R8: operand %h, expected 00000400", opnd_o);
    end
    apply(32'h1111_1111, 3'd0, 1'b0, 6'd3,  '0, 1'b1, 1'b1, 8'hF6, 4'd0);
    apply(32'h0000_0000, 3'd2, 1'b1, 6'd0,  '1, 1'b0, 1'b1, 8'hFF, 4'd1);
    // random patterns
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] ar;
      ar = $urandom;
      if ((n % 3) != 0) ar[7:0] = 8'($urandom_range(0, 40));
      apply($urandom, 3'($urandom_range(0, 7)), 1'($urandom), 6'($urandom), ar,
            1'($urandom), ($urandom_range(0, 4) == 0), 8'($urandom), 4'($urandom));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule